// File: doc/BRIEF.md
# Memory Protect and ROM Overlay Selector

This block sits between a processor's memory port and its memory arrays. For each read or write it decides whether the read-only array or the RAM answers, and whether a write may reach the RAM. A fixed read-only region of up to 4K words sits at a parameterised base address. The lowest 256 words of that region can be shadowed by RAM. All other addresses are served by RAM.

Software controls two mode bits by presenting control opcodes on a strobed opcode port. One bit picks the array that serves the low 256 read-only words. The other bit turns write protection on or off for an address window whose inclusive bounds are inputs. While protection is on, reads inside the window proceed as usual. A write inside the window is dropped, and a one-cycle violation pulse is raised.

Every output is registered. The decision for an access presented in cycle t appears in cycle t+1. An opcode strobed in cycle t changes the mode at the clock edge that ends cycle t, so it first affects accesses presented in cycle t+1.

Top module: `mem_guard_overlay`

## Requirements
- R1: After synchronous reset all outputs are low, the low read-only words are served by the read-only array, and write protection is on.
- R2: An access to a read-only-region address above its lowest 256 words always asserts `rom_sel_o` and never asserts `ram_we_o`, in either overlay mode.
- R3: After opcode 0x4045 is strobed, accesses to the lowest 256 read-only words assert `ram_sel_o`, and writes there assert `ram_we_o` unless protection blocks them.
- R4: After opcode 0x4046 is strobed, accesses to the lowest 256 read-only words assert `rom_sel_o` again.
- R5: After opcode 0x4000 (or after reset), a write whose address lies in the protected window keeps `ram_we_o` low and raises `viol_o` for exactly one cycle.
- R6: A read inside the protected window is routed as usual and never raises `viol_o` or `ram_we_o`.
- R7: After opcode 0x4001, writes inside the window reach RAM (`ram_we_o` high, no violation) until 0x4000 is strobed again.
- R8: The window bounds `prot_lo_i` and `prot_hi_i` are both inclusive. Addresses one below the lower bound and one above the upper bound are not protected.
- R9: Outputs are registered one cycle after the request. When neither strobe is high, all four outputs are low in the next cycle. `rom_sel_o` and `ram_sel_o` are never both high.
- R10: An opcode with `op_stb_i` low, or any opcode value other than the four above, leaves both modes unchanged.
- R11: An access outside the read-only region asserts `ram_sel_o`. A write there asserts `ram_we_o` unless it is protected.
- R12: An access presented in the same cycle as a mode opcode is decided with the mode that was in effect before that opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address of the access |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| op_stb_i | input | 1 | Control opcode valid |
| op_i | input | OP_W | Control opcode |
| prot_lo_i | input | ADDR_W | Lowest protected address (inclusive) |
| prot_hi_i | input | ADDR_W | Highest protected address (inclusive) |
| rom_sel_o | output | 1 | Read-only array selected |
| ram_sel_o | output | 1 | RAM selected |
| ram_we_o | output | 1 | Gated RAM write enable |
| viol_o | output | 1 | One-cycle pulse for a suppressed write |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle. The outputs for a simultaneous read and write are not defined beyond the write taking effect. The bench drives at most one strobe per cycle, in both the directed part and the random part. The assertions also assume the read-only region fits inside the address space. The default parameters and every address the bench uses keep to that. The window bounds may change from cycle to cycle, but the bench holds them steady across each access so that the bench model samples the same bounds the design does.

// File: rtl/mgo_pkg.sv
package mgo_pkg;

  // Which array an access is steered to
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_ROM  = 2'd1,
    TGT_RAM  = 2'd2
  } mgo_tgt_e;

  // Per-access decision, registered at the block edge
  typedef struct packed {
    logic rom_sel;
    logic ram_sel;
    logic we;
    logic viol;
  } mgo_out_t;

  localparam mgo_out_t MGO_OUT_IDLE = '{rom_sel: 1'b0, ram_sel: 1'b0, we: 1'b0, viol: 1'b0};

endpackage

// File: rtl/mgo_mode_regs.sv
module mgo_mode_regs #(
  parameter int          OP_W     = 16,
  parameter logic [15:0] OP_RAM   = 16'h4045,
  parameter logic [15:0] OP_ROM   = 16'h4046,
  parameter logic [15:0] OP_P_ON  = 16'h4000,
  parameter logic [15:0] OP_P_OFF = 16'h4001
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_stb,
  input  logic [OP_W-1:0] op,
  output logic            ram_mode,
  output logic            prot_en
);

  localparam logic [OP_W-1:0] K_RAM  = OP_W'(OP_RAM);
  localparam logic [OP_W-1:0] K_ROM  = OP_W'(OP_ROM);
  localparam logic [OP_W-1:0] K_PON  = OP_W'(OP_P_ON);
  localparam logic [OP_W-1:0] K_POFF = OP_W'(OP_P_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_mode <= 1'b0;
      prot_en  <= 1'b1;
    end else if (op_stb) begin
      if (op == K_RAM)  ram_mode <= 1'b1;
      if (op == K_ROM)  ram_mode <= 1'b0;
      if (op == K_PON)  prot_en  <= 1'b1;
      if (op == K_POFF) prot_en  <= 1'b0;
    end
  end

endmodule

// File: rtl/mgo_addr_decode.sv
module mgo_addr_decode
  import mgo_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int ROM_BASE     = 'hF000,
  parameter int ROM_WORDS    = 4096,
  parameter int SHADOW_WORDS = 256
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic              ram_mode,
  input  logic              prot_en,
  output mgo_out_t          dec
);

  localparam logic [ADDR_W-1:0] BASE_V   = ADDR_W'(ROM_BASE);
  localparam logic [ADDR_W:0]   SPAN_V   = (ADDR_W+1)'(ROM_WORDS);
  localparam logic [ADDR_W:0]   SHADOW_V = (ADDR_W+1)'(SHADOW_WORDS);

  logic [ADDR_W-1:0] offset;
  logic              in_rom;
  logic              in_shadow;
  logic              in_window;
  logic              blocked;
  mgo_tgt_e          tgt;

  // Offset compare keeps a region that ends at the top of the space exact
  assign offset    = addr - BASE_V;
  assign in_rom    = (addr >= BASE_V) && ({1'b0, offset} < SPAN_V);
  assign in_shadow = in_rom && ({1'b0, offset} < SHADOW_V);
  assign in_window = (addr >= lo) && (addr <= hi);
  assign blocked   = wr && prot_en && in_window;

  always_comb begin
    if (!(rd || wr))                    tgt = TGT_NONE;
    else if (in_rom && !(in_shadow && ram_mode)) tgt = TGT_ROM;
    else                                tgt = TGT_RAM;
  end

  always_comb begin
    dec         = MGO_OUT_IDLE;
    dec.rom_sel = (tgt == TGT_ROM);
    dec.ram_sel = (tgt == TGT_RAM);
    dec.we      = wr && (tgt == TGT_RAM) && !blocked;
    dec.viol    = blocked;
  end

endmodule

// File: rtl/mgo_out_stage.sv
module mgo_out_stage
  import mgo_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  mgo_out_t d,
  output mgo_out_t q
);

  always_ff @(posedge clk) begin
    if (rst) q <= MGO_OUT_IDLE;
    else     q <= d;
  end

endmodule

// File: rtl/mem_guard_overlay.sv
module mem_guard_overlay
  import mgo_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int OP_W         = 16,
  parameter int ROM_BASE     = 'hF000,
  parameter int ROM_WORDS    = 4096,
  parameter int SHADOW_WORDS = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              op_stb_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [ADDR_W-1:0] prot_lo_i,
  input  logic [ADDR_W-1:0] prot_hi_i,
  output logic              rom_sel_o,
  output logic              ram_sel_o,
  output logic              ram_we_o,
  output logic              viol_o
);

  logic     ram_mode;
  logic     prot_en;
  mgo_out_t dec;
  mgo_out_t q;

  mgo_mode_regs #(.OP_W(OP_W)) u_modes (
    .clk      (clk),
    .rst      (rst),
    .op_stb   (op_stb_i),
    .op       (op_i),
    .ram_mode (ram_mode),
    .prot_en  (prot_en)
  );

  mgo_addr_decode #(
    .ADDR_W       (ADDR_W),
    .ROM_BASE     (ROM_BASE),
    .ROM_WORDS    (ROM_WORDS),
    .SHADOW_WORDS (SHADOW_WORDS)
  ) u_decode (
    .addr     (addr_i),
    .rd       (rd_i),
    .wr       (wr_i),
    .lo       (prot_lo_i),
    .hi       (prot_hi_i),
    .ram_mode (ram_mode),
    .prot_en  (prot_en),
    .dec      (dec)
  );

  mgo_out_stage u_out (
    .clk (clk),
    .rst (rst),
    .d   (dec),
    .q   (q)
  );

  assign rom_sel_o = q.rom_sel;
  assign ram_sel_o = q.ram_sel;
  assign ram_we_o  = q.we;
  assign viol_o    = q.viol;

endmodule

// File: rtl/mgo_checker.sv
module mgo_checker #(
  parameter int ADDR_W       = 16,
  parameter int ROM_BASE     = 'hF000,
  parameter int ROM_WORDS    = 4096,
  parameter int SHADOW_WORDS = 256
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic              rom_sel_o,
  input logic              ram_sel_o,
  input logic              ram_we_o,
  input logic              viol_o
);

  longint unsigned a;
  logic            upper_rom;
  logic            outside;

  always_comb begin
    a         = longint'(addr_i);
    upper_rom = (a >= longint'(ROM_BASE) + longint'(SHADOW_WORDS)) &&
                (a <  longint'(ROM_BASE) + longint'(ROM_WORDS));
    outside   = (a < longint'(ROM_BASE)) || (a >= longint'(ROM_BASE) + longint'(ROM_WORDS));
  end

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !(rd_i || wr_i) |=> !(rom_sel_o || ram_sel_o || ram_we_o || viol_o));

  a_r9_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_sel_o, ram_sel_o}));

  a_r5_viol_blocks_we: assert property (@(posedge clk) disable iff (rst)
    viol_o |-> !ram_we_o);

  a_r5_viol_from_write: assert property (@(posedge clk) disable iff (rst)
    viol_o |-> $past(wr_i));

  a_r2_upper_is_rom: assert property (@(posedge clk) disable iff (rst)
    ((rd_i || wr_i) && upper_rom) |=> (rom_sel_o && !ram_we_o));

  a_r11_outside_is_ram: assert property (@(posedge clk) disable iff (rst)
    ((rd_i || wr_i) && outside) |=> ram_sel_o);

  a_r6_read_clean: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !wr_i) |=> (!viol_o && !ram_we_o));

endmodule

bind mem_guard_overlay mgo_checker #(
  .ADDR_W       (ADDR_W),
  .ROM_BASE     (ROM_BASE),
  .ROM_WORDS    (ROM_WORDS),
  .SHADOW_WORDS (SHADOW_WORDS)
) u_mgo_checker (
  .clk       (clk),
  .rst       (rst),
  .addr_i    (addr_i),
  .rd_i      (rd_i),
  .wr_i      (wr_i),
  .rom_sel_o (rom_sel_o),
  .ram_sel_o (ram_sel_o),
  .ram_we_o  (ram_we_o),
  .viol_o    (viol_o)
);

// File: tb/mem_guard_overlay_bench.sv
`timescale 1ns/1ps
module mem_guard_overlay_bench;

  localparam int BASE = 'hF000;
  localparam int SPAN = 4096;
  localparam int SHAD = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0, op_stb_i = 1'b0;
  logic [15:0] op_i = '0;
  logic [15:0] prot_lo_i, prot_hi_i;
  logic        rom_sel_o, ram_sel_o, ram_we_o, viol_o;

  int checks = 0;
  int errors = 0;
  bit m_ram;
  bit m_prot;
  int lo = 'h0100;
  int hi = 'h01FF;

  always #4 clk = ~clk;

  mem_guard_overlay u_mem_guard_overlay (
    .clk(clk), .rst(rst), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .op_stb_i(op_stb_i), .op_i(op_i), .prot_lo_i(prot_lo_i), .prot_hi_i(prot_hi_i),
    .rom_sel_o(rom_sel_o), .ram_sel_o(ram_sel_o), .ram_we_o(ram_we_o), .viol_o(viol_o)
  );

  assign prot_lo_i = lo[15:0];
  assign prot_hi_i = hi[15:0];

  task automatic compare(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {rom_sel_o, ram_sel_o, ram_we_o, viol_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {rom,ram,we,viol} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, then compare the registered result
  task automatic step(input string tag, input bit rd, input bit wr, input int a,
                      input bit stb, input int op);
    bit rom_t, ram_t, hit;
    logic [3:0] exp;
    rd_i = rd; wr_i = wr; addr_i = a[15:0]; op_stb_i = stb; op_i = op[15:0];
    rom_t = 0; ram_t = 0; hit = 0;
    if (rd || wr) begin
      if (a >= BASE && a < BASE + SPAN && !(a < BASE + SHAD && m_ram)) rom_t = 1;
      else ram_t = 1;
    end
    if (wr && m_prot && a >= lo && a <= hi) hit = 1;
    exp = {rom_t, ram_t, wr && ram_t && !hit, hit};
    @(posedge clk);
    if (stb) begin
      if (op == 'h4045) m_ram = 1;
      else if (op == 'h4046) m_ram = 0;
      else if (op == 'h4000) m_prot = 1;
      else if (op == 'h4001) m_prot = 0;
    end
    @(negedge clk);
    rd_i = 0; wr_i = 0; op_stb_i = 0;
    compare(tag, exp);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0);
  endtask

  task automatic opc(input string tag, input int op);
    step(tag, 0, 0, 0, 1, op);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    compare("R1 outputs during reset", 4'b0000);
    rst = 0; m_ram = 0; m_prot = 1;
    compare("R1 outputs after reset", 4'b0000);
    step("R1 shadow read from rom", 1, 0, 'hF010, 0, 0);
    step("R1 protection on", 0, 1, 'h0150, 0, 0);
    step("R5 pulse lasts one cycle", 1, 0, 'h0020, 0, 0);
    step("R2 upper read", 1, 0, 'hF100, 0, 0);
    step("R2 top word write", 0, 1, 'hFFFF, 0, 0);
    step("R11 low ram read", 1, 0, 'h0020, 0, 0);
    step("R11 low ram write", 0, 1, 'h0020, 0, 0);
    step("R11 just below region", 0, 1, 'hEFFF, 0, 0);
    opc("R3 select ram overlay", 'h4045);
    step("R3 shadow read to ram", 1, 0, 'hF000, 0, 0);
    step("R3 shadow write to ram", 0, 1, 'hF0FF, 0, 0);
    step("R2 upper stays rom in ram mode", 0, 1, 'hF100, 0, 0);
    step("R12 op same cycle as access", 1, 0, 'hF005, 1, 'h4046);
    step("R4 back to rom", 1, 0, 'hF005, 0, 0);
    step("R8 lower bound", 0, 1, 'h0100, 0, 0);
    step("R8 upper bound", 0, 1, 'h01FF, 0, 0);
    step("R8 below bound", 0, 1, 'h00FF, 0, 0);
    step("R8 above bound", 0, 1, 'h0200, 0, 0);
    step("R6 protected read", 1, 0, 'h0150, 0, 0);
    idle("R9 idle");
    opc("R7 disable protection", 'h4001);
    step("R7 write passes", 0, 1, 'h0150, 0, 0);
    step("R7 still writable", 0, 1, 'h01FF, 0, 0);
    opc("R5 enable protection", 'h4000);
    step("R5 write blocked", 0, 1, 'h0150, 0, 0);
    idle("R5 pulse ends");
    opc("R10 unknown opcode", 'h4002);
    rd_i = 0; op_i = 16'h4045;
    step("R10 opcode without strobe", 0, 0, 0, 0, 'h4045);
    step("R10 mode kept rom", 1, 0, 'hF000, 0, 0);
    step("R10 protection kept", 0, 1, 'h0150, 0, 0);
    lo = 'hF000; hi = 'hF0FF;
    opc("R3 ram mode again", 'h4045);
    step("R5 protected shadow write", 0, 1, 'hF080, 0, 0);
    step("R6 protected shadow read", 1, 0, 'hF080, 0, 0);
    lo = 'h0100; hi = 'h01FF;
    for (int i = 0; i < 600; i++) begin
      int kind;
      int a;
      int ops[5] = '{'h4045, 'h4046, 'h4000, 'h4001, 'h4003};
      kind = $urandom_range(0, 9);
      case ($urandom_range(0, 3))
        0: a = $urandom_range('hF000, 'hF0FF);
        1: a = $urandom_range('hF100, 'hFFFF);
        2: a = $urandom_range('h00F0, 'h0210);
        default: a = $urandom_range(0, 'hFFFF);
      endcase
      if (kind < 4)      step("R9 random read", 1, 0, a, kind == 0, ops[$urandom_range(0, 4)]);
      else if (kind < 8) step("R9 random write", 0, 1, a, kind == 4, ops[$urandom_range(0, 4)]);
      else if (kind == 8) opc("R9 random opcode", ops[$urandom_range(0, 4)]);
      else idle("R9 random idle");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule